// File: doc/BRIEF.md
# Memory Bus Toggle Stress Tester

This block drives a simple synchronous memory port with a short, fixed access sequence. The sequence is chosen so that as many address and data lines as possible switch together on each access. It does not walk the memory for coverage. It hammers two address pairs. The first pair is address zero and the all-ones address, so every address line switches between them. The second pair sits either side of the point where the low half of the address rolls over into the high half. Each pair is written and read back first with an all-ones data word and then with an all-zeros data word. The accesses run back to back with no idle cycles, and the loop repeats for as long as it is asked to.

A start pulse launches a run. The run lasts a given number of loops, or, when the count is zero, until a halt request arrives. The memory is assumed to return read data exactly one cycle after a read. Each returned word is checked in that cycle against the value written. The first mismatch is recorded with its address, the expected word and the observed word, and it sets a sticky fail flag. When the stop-on-error input is high, that mismatch also ends the run. At the end of a run a done flag rises and the number of completed loops is reported.

Top module: `bus_toggle_stress`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle: `busy`, `done`, `fail`, `loops_done`, `mem_we` and `mem_re` are 0 afterwards.
- R2: One loop is 16 accesses in four phases, in this order: pair (0, all-ones address) with data all-ones; the same pair with data all-zeros; pair (2^(AW/2)-1, 2^(AW/2)) with data all-ones (0x00FF and 0x0100 at AW=16); that pair with data all-zeros. Each phase writes the first address, then the second, then reads the first, then the second. A write has `mem_we`=1 and `mem_re`=0; a read has `mem_re`=1 and `mem_we`=0.
- R3: The first access is issued in the cycle after the edge that samples `start` high in idle. From then on, one access is issued every cycle, across loop boundaries too, until the run ends.
- R4: With `iterations`=N>0 exactly 16*N accesses are issued, followed by one cycle with `busy`=1 and no access. In the next cycle `busy`=0, `done`=1 and `loops_done`=N.
- R5: With `iterations`=0 the run continues until `halt` is sampled high. The access in that cycle is the last one. One cycle with `busy`=1 and no access follows, then `busy`=0 and `done`=1, with `loops_done` equal to the number of completed 16-access loops.
- R6: Read data on `mem_rdata` in the cycle after a read is compared with the word written to that address in the same phase. The first mismatch of a run sets `fail` and stores `fail_addr`, `fail_exp` and `fail_got`. Later mismatches in the same run leave all four unchanged.
- R7: With `stop_on_err`=1, a mismatch ends the run at that cycle's edge: no access is issued afterwards, `busy`=0 and `done`=1 in the next cycle, and the loop in progress is not counted.
- R8: A start accepted in idle clears `done`, `fail`, the stored failure fields and `loops_done`. A `start` pulse while `busy`=1 has no effect on the access stream or the loop count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch pulse, accepted only when idle |
| iterations | input | CW | Loop count for the run, 0 = until halted |
| stop_on_err | input | 1 | End the run at the first mismatch |
| halt | input | 1 | Ends the current run after this cycle's access |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | DW | Read data, valid one cycle after a read |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has ended |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW | Address of the first mismatch |
| fail_exp | output | DW | Expected word at the first mismatch |
| fail_got | output | DW | Observed word at the first mismatch |
| loops_done | output | CW | Completed loops in the current or last run |

## Verification
The first access appears in the cycle right after the edge that takes `start`, and the bench compares one access per cycle against its own generated stream from that cycle on, sampling on the falling edge. A read's data is checked in the cycle after the read, and the failure record becomes visible one cycle after that. The end of a run is therefore due at a fixed point: one drain cycle after the last access for a counted or halted run, or in the cycle right after the bad data when stopping on error. The bench samples `busy`, `done` and the counters at exactly those cycles.

// File: rtl/bts_pkg.sv
// Package: shared state encoding and loop-step layout for the bus toggle
// stress tester. A loop is 16 steps; the step number decodes directly into
// the address pair, the data polarity, the access kind and the address slot.
package bts_pkg;

    localparam int STEP_W         = 4;
    localparam int STEPS_PER_LOOP = 1 << STEP_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } bts_state_e;

    // Step bit 0 selects the second address of the pair.
    function automatic logic step_second(input logic [STEP_W-1:0] s);
        return s[0];
    endfunction

    // Step bit 1 marks the read half of a phase.
    function automatic logic step_is_read(input logic [STEP_W-1:0] s);
        return s[1];
    endfunction

    // Step bit 2 selects the all-zeros data word.
    function automatic logic step_zero_data(input logic [STEP_W-1:0] s);
        return s[2];
    endfunction

    // Step bit 3 selects the byte-rollover address pair.
    function automatic logic step_boundary(input logic [STEP_W-1:0] s);
        return s[3];
    endfunction

endpackage

// File: rtl/bts_pattern_gen.sv
// Module: bts_pattern_gen
// Turns a loop step into the address, the data word and the access kind.
// Purely combinational. Assumes AW >= 2 so that the rollover pair is distinct
// from the full-swing pair; the rollover point is the middle of the address.
module bts_pattern_gen
    import bts_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic [STEP_W-1:0] step,
    output logic [AW-1:0]     addr,
    output logic [DW-1:0]     wdata,
    output logic              is_read
);
    localparam int            HALF     = AW / 2;
    localparam logic [AW-1:0] SWING_A  = '0;
    localparam logic [AW-1:0] SWING_B  = '1;
    localparam logic [AW-1:0] ROLL_B   = AW'(1) << HALF;
    localparam logic [AW-1:0] ROLL_A   = ROLL_B - AW'(1);

    logic [AW-1:0] pair_first;
    logic [AW-1:0] pair_second;

    // Pick the address pair for this phase.
    always_comb begin
        if (step_boundary(step)) begin
            pair_first  = ROLL_A;
            pair_second = ROLL_B;
        end else begin
            pair_first  = SWING_A;
            pair_second = SWING_B;
        end
    end

    // Select the slot, the data polarity and the access kind.
    always_comb begin
        addr    = step_second(step) ? pair_second : pair_first;
        wdata   = step_zero_data(step) ? '0 : '1;
        is_read = step_is_read(step);
    end

endmodule

// File: rtl/bts_sequencer.sv
// Module: bts_sequencer
// Run control: accepts a start in idle, steps through the loop one access
// per cycle, counts completed loops and ends the run on count, halt or a
// stop request. A counted or halted run passes through one drain cycle so
// that the last read can still be checked. Synchronous active-low reset.
module bts_sequencer
    import bts_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CW-1:0]     iterations,
    input  logic              halt,
    input  logic              stop_req,
    output logic              issue,
    output logic              accept,
    output logic [STEP_W-1:0] step,
    output logic [CW-1:0]     loops_done,
    output logic              busy,
    output logic              done
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS_PER_LOOP - 1);

    bts_state_e        state_q;
    logic [STEP_W-1:0] step_q;
    logic [CW-1:0]     loops_q;
    logic [CW-1:0]     target_q;
    logic              done_q;
    logic              loop_end;
    logic              last_loop;

    // Decode loop-end conditions from the step and the loop target.
    always_comb begin
        loop_end  = (step_q == LAST_STEP);
        last_loop = (target_q != '0) && (loops_q == target_q - CW'(1));
        issue     = (state_q == ST_RUN);
        accept    = (state_q == ST_IDLE) && start;
    end

    // Main run state, step counter, loop counter and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            step_q   <= '0;
            loops_q  <= '0;
            target_q <= '0;
            done_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q  <= ST_RUN;
                        step_q   <= '0;
                        loops_q  <= '0;
                        target_q <= iterations;
                        done_q   <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (stop_req) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        step_q <= step_q + STEP_W'(1);
                        if (loop_end) begin
                            loops_q <= loops_q + CW'(1);
                        end
                        if (halt || (loop_end && last_loop)) begin
                            state_q <= ST_DRAIN;
                        end
                    end
                end
                ST_DRAIN: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign step       = step_q;
    assign loops_done = loops_q;
    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;

endmodule

// File: rtl/bts_read_check.sv
// Module: bts_read_check
// Holds the expectation of the read issued last cycle and compares it with
// the memory's read data, which is assumed to arrive exactly one cycle after
// the read. Records only the first mismatch of a run. Synchronous active-low
// reset; a new run clears the record.
module bts_read_check #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          rd_issue,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_exp,
    input  logic [DW-1:0] mem_rdata,
    output logic          mismatch,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_exp,
    output logic [DW-1:0] fail_got
);
    logic          pend_valid;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_exp;

    // Compare returning data with the pending expectation.
    always_comb begin
        mismatch = pend_valid && (mem_rdata != pend_exp);
    end

    // Pipeline register carrying the outstanding read's expectation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_exp   <= '0;
        end else begin
            pend_valid <= rd_issue;
            pend_addr  <= rd_addr;
            pend_exp   <= rd_exp;
        end
    end

    // First-failure record with a sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_got  <= '0;
        end else if (mismatch && !fail) begin
            fail      <= 1'b1;
            fail_addr <= pend_addr;
            fail_exp  <= pend_exp;
            fail_got  <= mem_rdata;
        end
    end

endmodule

// File: rtl/bus_toggle_stress.sv
// Module: bus_toggle_stress
// Top of the bus toggle stress tester. Drives a synchronous memory port with
// back-to-back accesses that swing every address and data line, plus accesses
// across the half-address rollover, and checks the read-back. Assumes a fixed
// one-cycle read latency and that the memory accepts one access per cycle.
// Synchronous active-low reset.
module bus_toggle_stress
    import bts_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] iterations,
    input  logic          stop_on_err,
    input  logic          halt,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_exp,
    output logic [DW-1:0] fail_got,
    output logic [CW-1:0] loops_done
);
    logic              issue;
    logic              accept;
    logic [STEP_W-1:0] step;
    logic [AW-1:0]     pat_addr;
    logic [DW-1:0]     pat_data;
    logic              pat_read;
    logic              mismatch;
    logic              stop_req;

    bts_sequencer #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .iterations (iterations),
        .halt       (halt),
        .stop_req   (stop_req),
        .issue      (issue),
        .accept     (accept),
        .step       (step),
        .loops_done (loops_done),
        .busy       (busy),
        .done       (done)
    );

    bts_pattern_gen #(.AW(AW), .DW(DW)) u_pat (
        .step    (step),
        .addr    (pat_addr),
        .wdata   (pat_data),
        .is_read (pat_read)
    );

    bts_read_check #(.AW(AW), .DW(DW)) u_chk_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .rd_issue  (issue && pat_read),
        .rd_addr   (pat_addr),
        .rd_exp    (pat_data),
        .mem_rdata (mem_rdata),
        .mismatch  (mismatch),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_exp  (fail_exp),
        .fail_got  (fail_got)
    );

    // Stop request goes to the sequencer when the stop option is set.
    always_comb begin
        stop_req = mismatch && stop_on_err;
    end

    // Drive the memory port only while a run is issuing.
    always_comb begin
        mem_we    = issue && !pat_read;
        mem_re    = issue && pat_read;
        mem_addr  = issue ? pat_addr : '0;
        mem_wdata = (issue && !pat_read) ? pat_data : '0;
    end

endmodule

// File: rtl/bts_checker.sv
// Module: bts_checker
// Temporal properties of the tester's ports, attached to every instance of
// the top with a bind. Observes only; drives nothing.
module bts_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          stop_on_err,
    input logic          mem_we,
    input logic          mem_re,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic [CW-1:0] loops_done
);

    // R2: an access is never both a read and a write.
    assert_we_re_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R3: the memory port is quiet outside a run.
    assert_access_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> busy);

    // R8: an accepted start opens a run with cleared status.
    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done && !fail));

    // R6: the fail flag holds until a new start.
    assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail);

    // R7: a first failure found with the stop option set leaves the block idle.
    assert_stop_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fail) && $past(stop_on_err)) |-> (!busy && done));

    // R4: within a run the loop count advances by at most one per cycle.
    assert_loop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            ((loops_done == $past(loops_done)) ||
             (loops_done == $past(loops_done) + CW'(1))));

endmodule

bind bus_toggle_stress bts_checker #(.CW(CW)) u_bts_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .stop_on_err (stop_on_err),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .busy        (busy),
    .done        (done),
    .fail        (fail),
    .loops_done  (loops_done)
);

// File: tb/sim_bus_toggle_stress.sv
// Bench for bus_toggle_stress: a behavioural memory with injectable stuck
// bits, an expected access stream built from the requirements, and a
// per-cycle comparison sampled on the falling clock edge.
module sim_bus_toggle_stress;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] iterations = '0;
    logic          stop_on_err = 1'b0;
    logic          halt = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic          mem_re;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy;
    logic          done;
    logic          fail;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_exp;
    logic [DW-1:0] fail_got;
    logic [CW-1:0] loops_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Memory model state and two stuck-bit fault slots.
    logic [DW-1:0] mem [logic [AW-1:0]];
    logic [AW-1:0] flt_addr [2];
    logic [DW-1:0] flt_mask [2];
    logic [DW-1:0] flt_val  [2];

    bus_toggle_stress #(.AW(AW), .DW(DW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .iterations(iterations),
        .stop_on_err(stop_on_err), .halt(halt),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
        .fail_exp(fail_exp), .fail_got(fail_got), .loops_done(loops_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Synchronous memory with one-cycle read latency and fault injection.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] = mem_wdata;
        if (mem_re) begin
            logic [DW-1:0] v;
            v = mem.exists(mem_addr) ? mem[mem_addr] : '0;
            for (int k = 0; k < 2; k++)
                if (flt_mask[k] != '0 && flt_addr[k] == mem_addr)
                    v = (v & ~flt_mask[k]) | (flt_val[k] & flt_mask[k]);
            mem_rdata <= v;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected access i of a run, from the loop layout in R2.
    task automatic exp_access(input int i, output logic [AW-1:0] a,
                              output logic [DW-1:0] d, output bit rd);
        int s;
        int phase;
        int op;
        logic [AW-1:0] bnd;
        s = i % 16;
        phase = s / 4;
        op = s % 4;
        bnd = AW'(1) << (AW/2);
        if (phase >= 2) a = (op % 2 == 1) ? bnd : bnd - AW'(1);
        else            a = (op % 2 == 1) ? '1 : '0;
        d  = (phase % 2 == 1) ? '0 : '1;
        rd = (op >= 2);
    endtask

    task automatic clear_faults();
        for (int k = 0; k < 2; k++) begin
            flt_addr[k] = '0;
            flt_mask[k] = '0;
            flt_val[k]  = '0;
        end
    endtask

    // Pulse start in idle; returns in the cycle of the first access.
    task automatic launch(input int n, input bit stop);
        iterations  = CW'(n);
        stop_on_err = stop;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy && !done && !fail && loops_done == 0, "R8", "status cleared at start",
              {busy, done, fail}, 3'b100);
    endtask

    // Compare n_acc back-to-back accesses, then the end-of-run cycles.
    task automatic expect_run(input int n_acc, input int halt_at,
                              input int poke_at, input bit drain);
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        bit rd;
        for (int i = 0; i < n_acc; i++) begin
            exp_access(i, a, d, rd);
            check(mem_we || mem_re, "R3", "access present each cycle", {mem_we, mem_re}, 1);
            check(mem_addr == a && mem_re == rd && mem_we == !rd &&
                  (rd || mem_wdata == d), "R2", "access content",
                  {mem_re, mem_addr, mem_wdata}, {rd, a, rd ? mem_wdata : d});
            start = (i == poke_at);
            halt  = (i == halt_at);
            @(negedge clk);
        end
        start = 1'b0;
        halt  = 1'b0;
        if (drain) begin
            check(busy && !mem_we && !mem_re, "R4", "drain cycle",
                  {busy, mem_we, mem_re}, 3'b100);
            @(negedge clk);
        end
        check(!busy && done && !mem_we && !mem_re, "R4", "run ended with done",
              {busy, done, mem_we, mem_re}, 4'b0100);
    endtask

    initial begin
        clear_faults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(!busy && !done && !fail && loops_done == 0 && !mem_we && !mem_re,
              "R1", "reset state", {busy, done, fail, mem_we, mem_re}, 0);

        // Clean run of 3 loops with an ignored start pulse mid-run (R4, R8).
        launch(3, 1'b0);
        expect_run(48, -1, 20, 1'b1);
        check(loops_done == 3, "R4", "loops after counted run", loops_done, 3);
        check(!fail, "R6", "no failure on good memory", fail, 0);

        // Two faults: first mismatch at 0x0100 must be the one recorded (R6).
        flt_addr[0] = 16'h0100; flt_mask[0] = 16'h0001; flt_val[0] = 16'h0000;
        flt_addr[1] = 16'h00FF; flt_mask[1] = 16'h0010; flt_val[1] = 16'h0010;
        launch(2, 1'b0);
        expect_run(32, -1, -1, 1'b1);
        check(fail, "R6", "fail flag set", fail, 1);
        check(fail_addr == 16'h0100, "R6", "first fail address", fail_addr, 16'h0100);
        check(fail_exp == 16'hFFFF, "R6", "first fail expected", fail_exp, 16'hFFFF);
        check(fail_got == 16'hFFFE, "R6", "first fail observed", fail_got, 16'hFFFE);
        check(loops_done == 2, "R6", "run continues without stop", loops_done, 2);

        // Stop on error: bad read of the all-ones address at step 3 (R7).
        clear_faults();
        flt_addr[0] = 16'hFFFF; flt_mask[0] = 16'h8000; flt_val[0] = 16'h0000;
        launch(5, 1'b1);
        expect_run(5, -1, -1, 1'b0);
        check(fail && fail_addr == 16'hFFFF, "R7", "stop fail address", fail_addr, 16'hFFFF);
        check(fail_exp == 16'hFFFF && fail_got == 16'h7FFF, "R7", "stop fail data",
              {fail_exp, fail_got}, {16'hFFFF, 16'h7FFF});
        check(loops_done == 0, "R7", "incomplete loop not counted", loops_done, 0);
        @(negedge clk);
        check(!busy && !mem_we && !mem_re, "R7", "no access after stop",
              {busy, mem_we, mem_re}, 0);

        // Unbounded run ended by halt after 37 accesses (R5); status clear (R8).
        clear_faults();
        launch(0, 1'b0);
        expect_run(37, 36, -1, 1'b1);
        check(loops_done == 2, "R5", "loops after halt", loops_done, 2);
        check(!fail, "R8", "fail cleared by new run", fail, 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule